// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the part of an I2C master that finishes a byte and finishes a transfer. After the master has received a byte, an acknowledge strobe makes it clock out one acknowledge bit. An ACK pulls SDA low and a NACK leaves SDA released. A stop strobe makes it generate the stop condition: SDA rises while SCL is high. Both sequences run from an internal down-counting baud generator. The generator reloads from a 7-bit value, so one bit period lasts reload+1 system clocks.

Both bus lines are driven as open-drain pull enables, where 1 pulls the line low. The lines are read back through two-flop synchronizers. Every phase that follows a line release waits for the synchronized line to read high before the baud counter reloads. A slave that stretches SCL therefore lengthens the high phase by exactly the stretch time.

The block keeps a sticky interrupt flag and a sticky write-collision flag. It also keeps a stop-detected flag and holds the transmit buffer register. A write to that buffer while a sequence runs is refused and flagged.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: A pulse on ack_go while no sequence runs sets ack_active and sets scl_pull to 1. On the same edge, sda_pull becomes the inverse of ack_bit: ack_bit=0 gives ACK with sda_pull=1, and ack_bit=1 gives NACK with sda_pull=0.
- R2: During an acknowledge, scl_pull stays 1 for reload+1 clocks, counted from the edge that accepted ack_go, and then drops to 0.
- R3: After an SCL release, the counter reloads only once the synchronized SCL reads high. scl_pull (acknowledge) or sda_pull (stop) returns low reload+4+S clocks after the release, where S is the number of extra clocks a slave holds SCL low.
- R4: At the end of an acknowledge, scl_pull returns to 1, ack_active clears and irq sets, all on the same edge.
- R5: A pulse on stop_go while no sequence runs sets stop_active and sda_pull. Once the synchronized SDA reads low, the counter runs one period and then scl_pull drops to 0. From the accepting edge this takes reload+2 clocks if SDA was already pulled, and reload+4 clocks otherwise.
- R6: During a stop, sda_pull drops to 0 after SCL has been released and sampled high plus one period. The delay follows the timing of R3.
- R7: stop_seen sets 3 clocks after SDA is released, once synchronized SDA and SCL both read high. It clears on the edge that accepts the next ack_go or stop_go.
- R8: irq sets and stop_active clears reload+1 clocks after stop_seen sets. Both lines then stay released.
- R9: When buf_wr is pulsed while a sequence runs, wr_col sets and buf_q keeps its value. When buf_wr is pulsed while idle, buf_q takes buf_wdata and wr_col does not change.
- R10: irq and wr_col stay set until irq_clr or wcol_clr, respectively, is pulsed.
- R11: If ack_go and stop_go arrive together, only the acknowledge starts. Strobes that arrive while a sequence runs are ignored.
- R12: After reset, both pull enables, all flags, both active outputs and buf_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload | input | 7 | Baud counter reload value; period is reload+1 clocks |
| ack_go | input | 1 | Strobe that starts an acknowledge |
| ack_bit | input | 1 | Acknowledge value: 0 gives ACK, 1 gives NACK |
| stop_go | input | 1 | Strobe that starts a stop condition |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| irq_clr | input | 1 | Clears irq |
| wcol_clr | input | 1 | Clears wr_col |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| ack_active | output | 1 | Acknowledge in progress; clears itself |
| stop_active | output | 1 | Stop in progress; clears itself |
| stop_seen | output | 1 | Stop condition observed on the bus |
| irq | output | 1 | Sticky completion interrupt |
| wr_col | output | 1 | Sticky write-collision flag |
| buf_q | output | 8 | Transmit buffer contents |

## Verification
A table of cases runs an acknowledge and then a stop for each case. The cases mix reload values 0, 3, 10 and 127, clock stretch lengths of 0, 2 and 5 cycles, and both acknowledge values. Varying the reload separates the fixed period (reload+1) from the wait that follows a release (reload+4+S). Varying the stretch shows that the counter waits on the synchronized line rather than on its own release. The two acknowledge values tell apart the two SDA-low entry delays of a stop. Directed cases then cover the reset state, write collisions in both sequences against an idle write, sticky flags and their clears, the simultaneous-strobe priority, a stop strobe ignored during an acknowledge, and the clearing of stop_seen.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ACK_LOW,
        SQ_ACK_REL,
        SQ_ACK_HIGH,
        SQ_STP_SDA,
        SQ_STP_CNT1,
        SQ_STP_SCLW,
        SQ_STP_CNT2,
        SQ_STP_SDAW,
        SQ_STP_CNT3
    } seq_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)            cnt_d = reload;
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == 0);
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq
    import i2c_seq_pkg::*;
#(
    parameter int BRG_W  = 7,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BRG_W-1:0]  reload,
    input  logic              ack_go,
    input  logic              ack_bit,
    input  logic              stop_go,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              ack_active,
    output logic              stop_active,
    output logic              stop_seen,
    output logic              irq,
    output logic              wr_col,
    output logic [DATA_W-1:0] buf_q
);
    typedef struct packed {
        seq_state_e        st;
        logic              scl_pull;
        logic              sda_pull;
        logic              ack_act;
        logic              stop_act;
        logic              stop_seen;
        logic              irq;
        logic              wcol;
        logic [DATA_W-1:0] bufr;
    } seq_regs_t;

    localparam seq_regs_t RESET_REGS = '{
        st: SQ_IDLE, scl_pull: 1'b0, sda_pull: 1'b0, ack_act: 1'b0,
        stop_act: 1'b0, stop_seen: 1'b0, irq: 1'b0, wcol: 1'b0, bufr: '0};

    seq_regs_t r_q, r_d;
    logic      scl_s, sda_s, brg_done, brg_load, busy;

    i2c_line_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    i2c_line_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));
    i2c_baud_cnt #(.W(BRG_W)) u_brg (
        .clk(clk), .rst_n(rst_n), .load(brg_load), .reload(reload), .done(brg_done));

    assign busy = (r_q.st != SQ_IDLE);

    always_comb begin
        r_d      = r_q;
        brg_load = 1'b0;
        if (irq_clr)  r_d.irq  = 1'b0;
        if (wcol_clr) r_d.wcol = 1'b0;
        if (buf_wr) begin
            if (busy) r_d.wcol = 1'b1;
            else      r_d.bufr = buf_wdata;
        end
        case (r_q.st)
            SQ_IDLE: begin
                if (ack_go) begin
                    r_d.st        = SQ_ACK_LOW;
                    r_d.scl_pull  = 1'b1;
                    r_d.sda_pull  = !ack_bit;
                    r_d.ack_act   = 1'b1;
                    r_d.stop_seen = 1'b0;
                    brg_load      = 1'b1;
                end else if (stop_go) begin
                    r_d.st        = SQ_STP_SDA;
                    r_d.scl_pull  = 1'b1;
                    r_d.sda_pull  = 1'b1;
                    r_d.stop_act  = 1'b1;
                    r_d.stop_seen = 1'b0;
                end
            end
            SQ_ACK_LOW: if (brg_done) begin
                r_d.scl_pull = 1'b0;
                r_d.st       = SQ_ACK_REL;
            end
            SQ_ACK_REL: if (scl_s) begin
                brg_load = 1'b1;
                r_d.st   = SQ_ACK_HIGH;
            end
            SQ_ACK_HIGH: if (brg_done) begin
                r_d.scl_pull = 1'b1;
                r_d.ack_act  = 1'b0;
                r_d.irq      = 1'b1;
                r_d.st       = SQ_IDLE;
            end
            SQ_STP_SDA: if (!sda_s) begin
                brg_load = 1'b1;
                r_d.st   = SQ_STP_CNT1;
            end
            SQ_STP_CNT1: if (brg_done) begin
                r_d.scl_pull = 1'b0;
                r_d.st       = SQ_STP_SCLW;
            end
            SQ_STP_SCLW: if (scl_s) begin
                brg_load = 1'b1;
                r_d.st   = SQ_STP_CNT2;
            end
            SQ_STP_CNT2: if (brg_done) begin
                r_d.sda_pull = 1'b0;
                r_d.st       = SQ_STP_SDAW;
            end
            SQ_STP_SDAW: if (sda_s && scl_s) begin
                r_d.stop_seen = 1'b1;
                brg_load      = 1'b1;
                r_d.st        = SQ_STP_CNT3;
            end
            SQ_STP_CNT3: if (brg_done) begin
                r_d.stop_act = 1'b0;
                r_d.irq      = 1'b1;
                r_d.st       = SQ_IDLE;
            end
            default: r_d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    assign scl_pull    = r_q.scl_pull;
    assign sda_pull    = r_q.sda_pull;
    assign ack_active  = r_q.ack_act;
    assign stop_active = r_q.stop_act;
    assign stop_seen   = r_q.stop_seen;
    assign irq         = r_q.irq;
    assign wr_col      = r_q.wcol;
    assign buf_q       = r_q.bufr;

    // R1: acknowledge start drives SCL low and SDA per ack_bit
    a_r1_ack_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_active) |-> scl_pull && (sda_pull == !$past(ack_bit)));
    // R4: acknowledge end re-pulls SCL and raises irq
    a_r4_ack_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_active) |-> irq && scl_pull);
    // R7: stop detection only with both lines released during a stop
    a_r7_stop_seen: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> stop_active && !scl_pull && !sda_pull);
    // R8: stop end leaves lines released with flags set
    a_r8_stop_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_active) |-> irq && stop_seen && !scl_pull && !sda_pull);
    // R9: busy write collides and leaves buffer alone
    a_r9_wcol: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && (ack_active || stop_active)) |=> wr_col && $stable(buf_q));
    // R11: acknowledge wins a simultaneous request
    a_r11_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_go && stop_go && !ack_active && !stop_active) |=> ack_active && !stop_active);
endmodule

// File: tb/sim_i2c_ackstop_seq.sv
module sim_i2c_ackstop_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] reload = '0;
    logic       ack_go = 1'b0, ack_bit = 1'b0, stop_go = 1'b0;
    logic       irq_clr = 1'b0, wcol_clr = 1'b0, buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       stretch = 1'b0;
    logic       scl_pull, sda_pull, ack_active, stop_active, stop_seen, irq, wr_col;
    logic [7:0] buf_q;
    logic       scl_line, sda_line;
    int         total = 0, bad = 0;

    always #5 clk = ~clk;

    assign scl_line = !(scl_pull | stretch);
    assign sda_line = !sda_pull;

    i2c_ackstop_seq u0 (
        .clk(clk), .rst_n(rst_n), .reload(reload), .ack_go(ack_go), .ack_bit(ack_bit),
        .stop_go(stop_go), .scl_in(scl_line), .sda_in(sda_line), .irq_clr(irq_clr),
        .wcol_clr(wcol_clr), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .ack_active(ack_active),
        .stop_active(stop_active), .stop_seen(stop_seen), .irq(irq), .wr_col(wr_col),
        .buf_q(buf_q));

    // vector: {reload[6:0], stretch[3:0], ack_bit}
    localparam logic [11:0] VEC [4] = '{
        {7'd0,   4'd0, 1'b0},
        {7'd3,   4'd2, 1'b1},
        {7'd10,  4'd0, 1'b1},
        {7'd127, 4'd5, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic run_ack(input int n, input int s, input bit ab);
        int lo, hi, k;
        reload = 7'(n); ack_bit = ab; stretch = 1'b1; ack_go = 1'b1;
        @(negedge clk);
        ack_go = 1'b0;
        check("R1 ack_active", int'(ack_active), 1);
        check("R1 sda_pull", int'(sda_pull), int'(!ab));
        lo = 0;
        while (scl_pull && lo < 1000) begin lo++; @(negedge clk); end
        check("R2 scl low clocks", lo, n + 1);
        hi = 0; k = 0;
        while (!scl_pull && hi < 1000) begin
            if (k == s) stretch = 1'b0;
            k++; hi++;
            @(negedge clk);
        end
        check("R3 scl high clocks", hi, n + 4 + s);
        check("R4 ack_active cleared", int'(ack_active), 0);
        check("R4 irq set", int'(irq), 1);
        clear_irq();
    endtask

    task automatic run_stop(input int n, input int s, input bit prev_ab);
        int c, k;
        reload = 7'(n); stretch = 1'b1; stop_go = 1'b1;
        @(negedge clk);
        stop_go = 1'b0;
        check("R5 stop_active", int'(stop_active), 1);
        check("R5 sda_pull", int'(sda_pull), 1);
        c = 0;
        while (scl_pull && c < 1000) begin c++; @(negedge clk); end
        check("R5 scl release delay", c, prev_ab ? n + 4 : n + 2);
        c = 0; k = 0;
        while (sda_pull && c < 1000) begin
            if (k == s) stretch = 1'b0;
            k++; c++;
            @(negedge clk);
        end
        check("R6 sda release delay", c, n + 4 + s);
        c = 0;
        while (!stop_seen && c < 1000) begin c++; @(negedge clk); end
        check("R7 stop_seen delay", c, 3);
        c = 0;
        while (!irq && c < 1000) begin c++; @(negedge clk); end
        check("R8 irq delay", c, n + 1);
        check("R8 stop_active cleared", int'(stop_active), 0);
        check("R8 lines released", int'({scl_pull, sda_pull}), 0);
        clear_irq();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 pulls", int'({scl_pull, sda_pull}), 0);
        check("R12 flags", int'({ack_active, stop_active, stop_seen, irq, wr_col}), 0);
        check("R12 buf_q", int'(buf_q), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 4; i++) begin
            run_ack(int'(VEC[i][11:5]), int'(VEC[i][4:1]), VEC[i][0]);
            run_stop(int'(VEC[i][11:5]), int'(VEC[i][4:1]), VEC[i][0]);
        end

        // R9 idle write loads buffer, no collision
        buf_wdata = 8'hA5; buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        check("R9 idle write buf_q", int'(buf_q), 'hA5);
        check("R9 idle write wr_col", int'(wr_col), 0);

        // R7 stop_seen cleared by next accepted strobe; R11 priority
        check("R7 stop_seen before", int'(stop_seen), 1);
        reload = 7'd6; ack_bit = 1'b0; stretch = 1'b0;
        ack_go = 1'b1; stop_go = 1'b1;
        @(negedge clk);
        ack_go = 1'b0; stop_go = 1'b0;
        check("R7 stop_seen cleared", int'(stop_seen), 0);
        check("R11 ack wins", int'({ack_active, stop_active}), 2);
        // R9 collision during acknowledge
        buf_wdata = 8'h3C; buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        check("R9 busy write wr_col", int'(wr_col), 1);
        check("R9 busy write buf_q", int'(buf_q), 'hA5);
        // R11 stop strobe during acknowledge ignored
        stop_go = 1'b1;
        @(negedge clk);
        stop_go = 1'b0;
        for (int t = 0; t < 40 && !irq; t++) @(negedge clk);
        check("R4 irq after ack", int'(irq), 1);
        @(negedge clk);
        check("R11 ignored stop", int'(stop_active), 0);
        check("R11 sda unchanged", int'(sda_pull), 1);

        // R10 flags sticky until clears
        repeat (5) @(negedge clk);
        check("R10 irq sticky", int'(irq), 1);
        check("R10 wr_col sticky", int'(wr_col), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R10 irq cleared", int'(irq), 0);
        check("R10 wr_col kept", int'(wr_col), 1);
        wcol_clr = 1'b1;
        @(negedge clk);
        wcol_clr = 1'b0;
        check("R10 wr_col cleared", int'(wr_col), 0);

        // R9 collision during stop
        reload = 7'd2; stop_go = 1'b1;
        @(negedge clk);
        stop_go = 1'b0;
        buf_wdata = 8'h77; buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        check("R9 stop write wr_col", int'(wr_col), 1);
        check("R9 stop write buf_q", int'(buf_q), 'hA5);
        for (int t = 0; t < 60 && stop_active; t++) @(negedge clk);
        check("R8 stop done", int'({stop_active, irq}), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule